// File: doc/BRIEF.md
# Snooping Cache Line Coherence Controller

This block holds the coherence state of a single cache line on behalf of one processor attached to a shared snooping bus. The line is in one of three states: dirty (owned and modified), shared (clean copy), or invalid. Processor requests that can be served from the current state are answered at once. Any other request makes the block ask a bus arbiter for the bus, wait for the grant, release the arbiter, put a bus request out and wait for the bus reply. Requests placed on the bus by the other cache arrive on the bus input channel. The block snoops each one, changes the line state where needed and answers with a data supply or an acknowledge.

The new line state is committed when the grant arrives, and the processor is told its request is complete at that same moment. This happens before the bus transaction itself has run. Snooped requests are still served during the whole wait for the grant, so they can change the state before the commit.

Every channel is valid/ready with a small buffer at the block's edge. A transfer happens on a clock edge where valid and ready are both high. An output channel keeps valid high and its code stable until the transfer happens. The processor request channel's ready is also held low while a bus cycle is outstanding.

Top module: `snoop_line_ctrl`

## Requirements
- R1: After reset the line is invalid, no output channel is valid and `cpu_req_ready` is high.
- R2: A processor read (code 1) in the dirty or shared state returns a completion (code 14). In the invalid state it raises a claim (code 11), and the request it later issues is a shared read (code 4).
- R3: A processor write (code 2) completes at once only in the dirty state. Otherwise it raises a claim, and the request later issued is an invalidate (code 5).
- R4: A processor read-then-write (code 3) completes at once only in the dirty state. Otherwise it raises a claim, and the request later issued is an exclusive read (code 6).
- R5: A snooped shared read (code 4) in the dirty state moves the line to shared and is answered with a data supply (code 8). In any other state it is answered with an acknowledge (code 10).
- R6: A snooped invalidate (code 5) moves the line to invalid from any state and is answered with an invalidate acknowledge (code 7).
- R7: A snooped exclusive read (code 6) moves the line to invalid. It is answered with a data supply (code 8) if the line was dirty, and with an acknowledge (code 10) otherwise.
- R8: Snoops are served while the block waits for a grant. A snoop at the head of the bus input is handled before a grant or a processor request that is pending in the same cycle.
- R9: A grant (code 12) commits the line state: shared for a pending shared read, dirty for an invalidate or an exclusive read. It also emits the processor completion and an arbiter release (code 13). A grant channel item with any other code is consumed without effect.
- R10: After the release, the pending request is put on the bus output. The block then waits for a data reply (code 9) after a shared read or exclusive read, or for an acknowledge (code 10) after an invalidate. It returns to idle only when that reply arrives, and emits nothing on the bus output in the meantime.
- R11: Every channel has a buffer of `BUF_DEPTH` entries. An output held back by a low ready keeps its valid signal and code until it is taken.
- R12: `cpu_req_ready` is low from the moment a miss is accepted until the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request valid |
| cpu_req_ready | output | 1 | Processor request ready |
| cpu_req_code | input | 4 | Processor request code |
| cpu_rsp_valid | output | 1 | Completion valid |
| cpu_rsp_ready | input | 1 | Completion ready |
| cpu_rsp_code | output | 4 | Completion code |
| arb_claim_valid | output | 1 | Bus claim valid |
| arb_claim_ready | input | 1 | Bus claim ready |
| arb_claim_code | output | 4 | Claim code |
| arb_grant_valid | input | 1 | Grant valid |
| arb_grant_ready | output | 1 | Grant ready |
| arb_grant_code | input | 4 | Grant code |
| arb_free_valid | output | 1 | Arbiter release valid |
| arb_free_ready | input | 1 | Arbiter release ready |
| arb_free_code | output | 4 | Release code |
| bus_tx_valid | output | 1 | Bus output valid (requests and snoop answers) |
| bus_tx_ready | input | 1 | Bus output ready |
| bus_tx_code | output | 4 | Bus output code |
| bus_rx_valid | input | 1 | Bus input valid (snoops and replies) |
| bus_rx_ready | output | 1 | Bus input ready |
| bus_rx_code | input | 4 | Bus input code |

## Verification
The bench uses the default `BUF_DEPTH` of 2. With two entries, holding the completion ready low fills the completion buffer after two hits. A third hit then stalls inside the block, which exercises the hold rules of R11. Two entries also allow a reply and the snoop behind it to sit in the bus input buffer together. A snoop and a grant can be delivered in the same cycle, which shows the priority order of R8.

// File: rtl/snoop_pkg.sv
package snoop_pkg;

  localparam int CODE_W = 4;

  typedef enum logic [CODE_W-1:0] {
    MSG_NONE      = 4'd0,
    CPU_READ      = 4'd1,
    CPU_WRITE     = 4'd2,
    CPU_RDWR      = 4'd3,
    BUS_SHARED_RD = 4'd4,
    BUS_INVAL     = 4'd5,
    BUS_OWN_RD    = 4'd6,
    ANS_INV_ACK   = 4'd7,
    ANS_SUPPLY    = 4'd8,
    RPL_DATA      = 4'd9,
    MSG_ACK       = 4'd10,
    ARB_CLAIM     = 4'd11,
    ARB_GRANT     = 4'd12,
    ARB_FREE      = 4'd13,
    CPU_DONE      = 4'd14
  } msg_t;

  typedef enum logic [1:0] {
    LINE_DIRTY   = 2'd0,
    LINE_SHARED  = 2'd1,
    LINE_INVALID = 2'd2
  } line_st_t;

  typedef enum logic [2:0] {
    PH_IDLE      = 3'd0,
    PH_CLAIM     = 3'd1,
    PH_WAIT_GNT  = 3'd2,
    PH_ISSUE     = 3'd3,
    PH_WAIT_RPLY = 3'd4
  } phase_t;

endpackage

// File: rtl/snoop_fifo.sv
module snoop_fifo #(
  parameter int WIDTH = 4,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [WIDTH-1:0] in_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [WIDTH-1:0] out_data
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp, rp;
  logic [CW-1:0]    cnt;
  logic             push, pop;

  assign in_ready  = (cnt != FULL);
  assign out_valid = (cnt != '0);
  assign out_data  = mem[rp];
  assign push      = in_valid && in_ready;
  assign pop       = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  // R11: an offered item stays offered and unchanged until taken
  a_r11_hold_output: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

endmodule

// File: rtl/snoop_line_state.sv
module snoop_line_state
  import snoop_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     snoop_fire,
  input  msg_t     snoop_code,
  input  logic     commit,
  input  msg_t     pend_code,
  output line_st_t line_st,
  output msg_t     snoop_ans
);
  line_st_t st_nx;

  // Answer for the snoop at the bus input head, from the present state
  always_comb begin
    unique case (snoop_code)
      BUS_SHARED_RD: snoop_ans = (line_st == LINE_DIRTY) ? ANS_SUPPLY : MSG_ACK;
      BUS_INVAL:     snoop_ans = ANS_INV_ACK;
      BUS_OWN_RD:    snoop_ans = (line_st == LINE_DIRTY) ? ANS_SUPPLY : MSG_ACK;
      default:       snoop_ans = MSG_ACK;
    endcase
  end

  always_comb begin
    st_nx = line_st;
    if (snoop_fire) begin
      unique case (snoop_code)
        BUS_SHARED_RD: if (line_st == LINE_DIRTY) st_nx = LINE_SHARED;
        BUS_INVAL:     st_nx = LINE_INVALID;
        BUS_OWN_RD:    st_nx = LINE_INVALID;
        default:       st_nx = line_st;
      endcase
    end else if (commit) begin
      st_nx = (pend_code == BUS_SHARED_RD) ? LINE_SHARED : LINE_DIRTY;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) line_st <= LINE_INVALID;
    else        line_st <= st_nx;
  end

  // R8: the sequencer never commits in a cycle that serves a snoop
  a_r8_snoop_excludes_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !(snoop_fire && commit));

  // R6: an invalidate snoop always leaves the line invalid
  a_r6_inval_clears: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_fire && snoop_code == BUS_INVAL |=> line_st == LINE_INVALID);

  // R5: a shared-read snoop downgrades a dirty line
  a_r5_downgrade: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_fire && snoop_code == BUS_SHARED_RD && line_st == LINE_DIRTY
    |=> line_st == LINE_SHARED);

endmodule

// File: rtl/snoop_bus_seq.sv
module snoop_bus_seq
  import snoop_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  line_st_t line_st,
  input  msg_t     snoop_ans,
  input  logic     req_v,
  input  msg_t     req_code,
  output logic     req_pop,
  input  logic     rx_v,
  input  msg_t     rx_code,
  output logic     rx_pop,
  input  logic     gnt_v,
  input  msg_t     gnt_code,
  output logic     gnt_pop,
  output logic     tx_push,
  output msg_t     tx_code,
  input  logic     tx_room,
  output logic     rsp_push,
  input  logic     rsp_room,
  output logic     claim_push,
  input  logic     claim_room,
  output logic     free_push,
  input  logic     free_room,
  output logic     snoop_fire,
  output logic     commit,
  output msg_t     pend_code,
  output logic     at_idle
);
  phase_t phase, phase_nx;
  msg_t   pend_nx;
  logic   window, rx_busy, is_snoop, is_cpu, hit;
  msg_t   miss_code, want_reply;

  assign window     = (phase == PH_IDLE) || (phase == PH_CLAIM) || (phase == PH_WAIT_GNT);
  assign is_snoop   = (rx_code inside {BUS_SHARED_RD, BUS_INVAL, BUS_OWN_RD});
  assign rx_busy    = window && rx_v;
  assign is_cpu     = (req_code inside {CPU_READ, CPU_WRITE, CPU_RDWR});
  assign hit        = (req_code == CPU_READ) ? (line_st != LINE_INVALID)
                                             : (line_st == LINE_DIRTY);
  assign want_reply = (pend_code == BUS_INVAL) ? MSG_ACK : RPL_DATA;
  assign at_idle    = (phase == PH_IDLE);

  always_comb begin
    unique case (req_code)
      CPU_READ:  miss_code = BUS_SHARED_RD;
      CPU_WRITE: miss_code = BUS_INVAL;
      default:   miss_code = BUS_OWN_RD;
    endcase
  end

  always_comb begin
    phase_nx   = phase;
    pend_nx    = pend_code;
    req_pop    = 1'b0;
    rx_pop     = 1'b0;
    gnt_pop    = 1'b0;
    tx_push    = 1'b0;
    tx_code    = MSG_NONE;
    rsp_push   = 1'b0;
    claim_push = 1'b0;
    free_push  = 1'b0;
    snoop_fire = 1'b0;
    commit     = 1'b0;

    // Snoop service: ahead of the grant and the processor
    if (rx_busy) begin
      if (is_snoop) begin
        if (tx_room) begin
          snoop_fire = 1'b1;
          rx_pop     = 1'b1;
          tx_push    = 1'b1;
          tx_code    = snoop_ans;
        end
      end else begin
        rx_pop = 1'b1;
      end
    end

    unique case (phase)
      PH_IDLE: begin
        if (!rx_busy && req_v) begin
          if (!is_cpu) begin
            req_pop = 1'b1;
          end else if (hit) begin
            if (rsp_room) begin
              req_pop  = 1'b1;
              rsp_push = 1'b1;
            end
          end else begin
            req_pop  = 1'b1;
            pend_nx  = miss_code;
            phase_nx = PH_CLAIM;
          end
        end
      end
      PH_CLAIM: begin
        if (claim_room) begin
          claim_push = 1'b1;
          phase_nx   = PH_WAIT_GNT;
        end
      end
      PH_WAIT_GNT: begin
        if (!rx_busy && gnt_v) begin
          if (gnt_code != ARB_GRANT) begin
            gnt_pop = 1'b1;
          end else if (rsp_room && free_room) begin
            gnt_pop   = 1'b1;
            commit    = 1'b1;
            rsp_push  = 1'b1;
            free_push = 1'b1;
            phase_nx  = PH_ISSUE;
          end
        end
      end
      PH_ISSUE: begin
        if (tx_room) begin
          tx_push  = 1'b1;
          tx_code  = pend_code;
          phase_nx = PH_WAIT_RPLY;
        end
      end
      PH_WAIT_RPLY: begin
        if (rx_v && rx_code == want_reply) begin
          rx_pop   = 1'b1;
          phase_nx = PH_IDLE;
        end
      end
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      pend_code <= MSG_NONE;
    end else begin
      phase     <= phase_nx;
      pend_code <= pend_nx;
    end
  end

  // R9: a commit is followed by the bus request issue step
  a_r9_commit_then_issue: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> phase == PH_ISSUE && !commit);

  // R10: nothing leaves on the bus while the reply is awaited
  a_r10_quiet_wait: assert property (@(posedge clk) disable iff (!rst_n)
    phase == PH_WAIT_RPLY |-> !tx_push);

endmodule

// File: rtl/snoop_line_ctrl.sv
module snoop_line_ctrl
  import snoop_pkg::*;
#(
  parameter int BUF_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cpu_req_valid,
  output logic       cpu_req_ready,
  input  logic [3:0] cpu_req_code,
  output logic       cpu_rsp_valid,
  input  logic       cpu_rsp_ready,
  output logic [3:0] cpu_rsp_code,
  output logic       arb_claim_valid,
  input  logic       arb_claim_ready,
  output logic [3:0] arb_claim_code,
  input  logic       arb_grant_valid,
  output logic       arb_grant_ready,
  input  logic [3:0] arb_grant_code,
  output logic       arb_free_valid,
  input  logic       arb_free_ready,
  output logic [3:0] arb_free_code,
  output logic       bus_tx_valid,
  input  logic       bus_tx_ready,
  output logic [3:0] bus_tx_code,
  input  logic       bus_rx_valid,
  output logic       bus_rx_ready,
  input  logic [3:0] bus_rx_code
);
  localparam int CW = CODE_W;

  logic          at_idle, req_in_ready, req_in_valid;
  logic          req_v, req_pop, rx_v, rx_pop, gnt_v, gnt_pop;
  logic [CW-1:0] req_raw, rx_raw, gnt_raw;
  logic          tx_push, tx_room, rsp_push, rsp_room;
  logic          claim_push, claim_room, free_push, free_room;
  logic          snoop_fire, commit;
  msg_t          tx_code, pend_code, snoop_ans;
  line_st_t      line_st;

  // Processor acceptance is gated to idle: one request per bus cycle (R12)
  assign req_in_valid  = cpu_req_valid && at_idle;
  assign cpu_req_ready = req_in_ready && at_idle;

  snoop_fifo #(.WIDTH(CW), .DEPTH(BUF_DEPTH)) u_req_buf (
    .clk, .rst_n,
    .in_valid(req_in_valid), .in_ready(req_in_ready), .in_data(cpu_req_code),
    .out_valid(req_v), .out_ready(req_pop), .out_data(req_raw));

  snoop_fifo #(.WIDTH(CW), .DEPTH(BUF_DEPTH)) u_rx_buf (
    .clk, .rst_n,
    .in_valid(bus_rx_valid), .in_ready(bus_rx_ready), .in_data(bus_rx_code),
    .out_valid(rx_v), .out_ready(rx_pop), .out_data(rx_raw));

  snoop_fifo #(.WIDTH(CW), .DEPTH(BUF_DEPTH)) u_gnt_buf (
    .clk, .rst_n,
    .in_valid(arb_grant_valid), .in_ready(arb_grant_ready), .in_data(arb_grant_code),
    .out_valid(gnt_v), .out_ready(gnt_pop), .out_data(gnt_raw));

  snoop_fifo #(.WIDTH(CW), .DEPTH(BUF_DEPTH)) u_tx_buf (
    .clk, .rst_n,
    .in_valid(tx_push), .in_ready(tx_room), .in_data(tx_code),
    .out_valid(bus_tx_valid), .out_ready(bus_tx_ready), .out_data(bus_tx_code));

  snoop_fifo #(.WIDTH(CW), .DEPTH(BUF_DEPTH)) u_rsp_buf (
    .clk, .rst_n,
    .in_valid(rsp_push), .in_ready(rsp_room), .in_data(CPU_DONE),
    .out_valid(cpu_rsp_valid), .out_ready(cpu_rsp_ready), .out_data(cpu_rsp_code));

  snoop_fifo #(.WIDTH(CW), .DEPTH(BUF_DEPTH)) u_claim_buf (
    .clk, .rst_n,
    .in_valid(claim_push), .in_ready(claim_room), .in_data(ARB_CLAIM),
    .out_valid(arb_claim_valid), .out_ready(arb_claim_ready), .out_data(arb_claim_code));

  snoop_fifo #(.WIDTH(CW), .DEPTH(BUF_DEPTH)) u_free_buf (
    .clk, .rst_n,
    .in_valid(free_push), .in_ready(free_room), .in_data(ARB_FREE),
    .out_valid(arb_free_valid), .out_ready(arb_free_ready), .out_data(arb_free_code));

  snoop_line_state u_state (
    .clk, .rst_n,
    .snoop_fire, .snoop_code(msg_t'(rx_raw)),
    .commit, .pend_code,
    .line_st, .snoop_ans);

  snoop_bus_seq u_seq (
    .clk, .rst_n,
    .line_st, .snoop_ans,
    .req_v, .req_code(msg_t'(req_raw)), .req_pop,
    .rx_v, .rx_code(msg_t'(rx_raw)), .rx_pop,
    .gnt_v, .gnt_code(msg_t'(gnt_raw)), .gnt_pop,
    .tx_push, .tx_code, .tx_room,
    .rsp_push, .rsp_room,
    .claim_push, .claim_room,
    .free_push, .free_room,
    .snoop_fire, .commit, .pend_code,
    .at_idle);

  // R12: the processor port is closed whenever a bus cycle is outstanding
  a_r12_ready_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !at_idle |-> !cpu_req_ready);

endmodule

// File: tb/snoop_line_ctrl_tb.sv
module snoop_line_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic       cpu_req_valid = 0, cpu_rsp_ready = 1, arb_claim_ready = 1;
  logic       arb_grant_valid = 0, arb_free_ready = 1, bus_tx_ready = 1, bus_rx_valid = 0;
  logic [3:0] cpu_req_code = 0, arb_grant_code = 0, bus_rx_code = 0;
  logic       cpu_req_ready, cpu_rsp_valid, arb_claim_valid, arb_grant_ready;
  logic       arb_free_valid, bus_tx_valid, bus_rx_ready;
  logic [3:0] cpu_rsp_code, arb_claim_code, arb_free_code, bus_tx_code;

  snoop_line_ctrl u_dut (.*);

  localparam int ST_D = 0, ST_S = 1, ST_I = 2;
  int total = 0, fails = 0;
  int mdl = ST_I;
  int pend = 0;
  int    q_rsp[$], q_claim[$], q_free[$], q_tx[$];
  string t_rsp[$], t_claim[$], t_free[$], t_tx[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic observe(input int ch, input int got);
    int e; string t;
    total++;
    case (ch)
      0: if (q_rsp.size() == 0) e = -1; else begin e = q_rsp.pop_front(); t = t_rsp.pop_front(); end
      1: if (q_claim.size() == 0) e = -1; else begin e = q_claim.pop_front(); t = t_claim.pop_front(); end
      2: if (q_free.size() == 0) e = -1; else begin e = q_free.pop_front(); t = t_free.pop_front(); end
      default: if (q_tx.size() == 0) e = -1; else begin e = q_tx.pop_front(); t = t_tx.pop_front(); end
    endcase
    if (e < 0) begin
      fails++;
      $display("FAIL unexpected item on channel %0d (R11) actual=%0d expected=none", ch, got);
    end else if (got != e) begin
      fails++;
      $display("FAIL %s channel %0d actual=%0d expected=%0d", t, ch, got, e);
    end
  endtask

  // Scoreboard monitors: sample away from the active edge
  always @(negedge clk) if (rst_n && cpu_rsp_valid && cpu_rsp_ready) observe(0, cpu_rsp_code);
  always @(negedge clk) if (rst_n && arb_claim_valid && arb_claim_ready) observe(1, arb_claim_code);
  always @(negedge clk) if (rst_n && arb_free_valid && arb_free_ready) observe(2, arb_free_code);
  always @(negedge clk) if (rst_n && bus_tx_valid && bus_tx_ready) observe(3, bus_tx_code);

  task automatic gap(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic drive_cpu(input int c);
    @(posedge clk); #1 cpu_req_valid = 1; cpu_req_code = 4'(c);
    forever begin @(negedge clk); if (cpu_req_ready) break; end
    @(posedge clk); #1 cpu_req_valid = 0;
  endtask

  task automatic drive_rx(input int c);
    @(posedge clk); #1 bus_rx_valid = 1; bus_rx_code = 4'(c);
    forever begin @(negedge clk); if (bus_rx_ready) break; end
    @(posedge clk); #1 bus_rx_valid = 0;
  endtask

  task automatic drive_gnt(input int c);
    @(posedge clk); #1 arb_grant_valid = 1; arb_grant_code = 4'(c);
    forever begin @(negedge clk); if (arb_grant_ready) break; end
    @(posedge clk); #1 arb_grant_valid = 0;
  endtask

  // Driver: model the expected result, then stimulate
  task automatic cpu_op(input int c, input string tag);
    bit hit;
    hit = (c == 1) ? (mdl != ST_I) : (mdl == ST_D);
    if (hit) begin q_rsp.push_back(14); t_rsp.push_back(tag); end
    else begin
      q_claim.push_back(11); t_claim.push_back(tag);
      pend = (c == 1) ? 4 : (c == 2) ? 5 : 6;
    end
    drive_cpu(c);
    gap(6);
  endtask

  function automatic void model_snoop(input int c, input string tag);
    int a;
    if (c == 5) begin a = 7; mdl = ST_I; end
    else begin
      a = (mdl == ST_D) ? 8 : 10;
      if (c == 4) begin if (mdl == ST_D) mdl = ST_S; end
      else mdl = ST_I;
    end
    q_tx.push_back(a); t_tx.push_back(tag);
  endfunction

  function automatic void model_grant(input string tag);
    mdl = (pend == 4) ? ST_S : ST_D;
    q_rsp.push_back(14); t_rsp.push_back(tag);
    q_free.push_back(13); t_free.push_back(tag);
    q_tx.push_back(pend); t_tx.push_back(tag);
  endfunction

  task automatic snoop(input int c, input string tag);
    model_snoop(c, tag);
    drive_rx(c);
    gap(6);
  endtask

  task automatic grant(input string tag);
    model_grant(tag);
    drive_gnt(12);
    gap(6);
  endtask

  task automatic reply(input int c);
    drive_rx(c);
    gap(6);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog expired (R10) actual=hung expected=done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    gap(3);
    rst_n = 1;
    gap(1);
    // R1: reset state
    chk(cpu_req_ready == 1, "R1 cpu_req_ready", cpu_req_ready, 1);
    chk(!cpu_rsp_valid && !arb_claim_valid && !arb_free_valid && !bus_tx_valid,
        "R1 outputs idle", bus_tx_valid, 0);

    // R2: read miss from invalid, snoop while waiting (R8), grant (R9), reply (R10)
    cpu_op(1, "R2 read miss");
    chk(cpu_req_ready == 0, "R12 ready low after miss", cpu_req_ready, 0);
    snoop(4, "R8 snoop during grant wait");
    grant("R9 grant read");
    chk(cpu_req_ready == 0, "R12 ready low until reply", cpu_req_ready, 0);
    chk(bus_tx_valid == 0, "R10 quiet while waiting", bus_tx_valid, 0);
    reply(9);
    chk(cpu_req_ready == 1, "R10 back to idle", cpu_req_ready, 1);

    // R2 hit in shared, R3 write miss from shared
    cpu_op(1, "R2 read hit shared");
    cpu_op(2, "R3 write miss shared");
    grant("R3 grant write");
    reply(10);
    cpu_op(2, "R3 write hit dirty");
    cpu_op(3, "R4 rdwr hit dirty");
    cpu_op(1, "R2 read hit dirty");

    // R5 snooped shared read
    snoop(4, "R5 supply from dirty");
    snoop(4, "R5 ack in shared");

    // R4 miss in shared, R7 snoop while waiting, R9 bogus grant ignored
    cpu_op(3, "R4 rdwr miss shared");
    snoop(6, "R7 own read in shared");
    drive_gnt(14);
    gap(8);
    chk(cpu_rsp_valid == 0 && arb_free_valid == 0, "R9 foreign grant code ignored",
        cpu_rsp_valid, 0);
    grant("R9 grant rdwr");
    reply(9);

    // R7 and R6 snoops
    snoop(6, "R7 supply from dirty");
    snoop(6, "R7 ack in invalid");
    snoop(5, "R6 inval in invalid");

    // R3 write miss from invalid; reply then snoop back to back (R10)
    cpu_op(2, "R3 write miss invalid");
    grant("R9 grant inval");
    chk(bus_tx_valid == 0 && cpu_req_ready == 0, "R10 waits for acknowledge", bus_tx_valid, 0);
    model_snoop(5, "R10 snoop after reply");
    drive_rx(10);
    drive_rx(5);
    gap(8);
    chk(cpu_req_ready == 1, "R10 idle after acknowledge", cpu_req_ready, 1);

    // R8 priority: snoop and grant in the same cycle
    cpu_op(1, "R2 read miss for priority");
    grant("R9 grant shared");
    reply(9);
    cpu_op(2, "R8 write miss shared");
    model_snoop(6, "R8 snoop before grant");
    model_grant("R8 grant after snoop");
    @(posedge clk); #1;
    bus_rx_valid = 1; bus_rx_code = 4'd6; arb_grant_valid = 1; arb_grant_code = 4'd12;
    forever begin @(negedge clk); if (bus_rx_ready && arb_grant_ready) break; end
    @(posedge clk); #1 bus_rx_valid = 0; arb_grant_valid = 0;
    gap(6);
    reply(10);
    cpu_op(2, "R8 commit wins over earlier snoop");

    // R11 back-pressure on completions
    cpu_rsp_ready = 0;
    cpu_op(1, "R11 held completion 1");
    cpu_op(1, "R11 held completion 2");
    cpu_op(1, "R11 held completion 3");
    chk(cpu_rsp_valid == 1 && cpu_rsp_code == 4'd14, "R11 valid held", cpu_rsp_valid, 1);
    cpu_rsp_ready = 1;
    gap(10);

    chk(q_rsp.size() == 0, "R11 completions drained", q_rsp.size(), 0);
    chk(q_claim.size() == 0, "R2 claims drained", q_claim.size(), 0);
    chk(q_free.size() == 0, "R9 releases drained", q_free.size(), 0);
    chk(q_tx.size() == 0, "R10 bus items drained", q_tx.size(), 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule